// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit unsigned operands and a carry-in, and returns a 20-bit sum with a carry-out. It is purely combinational. The word is split into five carry-select stages of 2, 3, 4, 5 and 6 bits, starting from the least significant end, so each stage is one bit wider than the one below it.

Every stage first forms a propagate bit (A xor B) and a generate bit (A and B) for each of its bit positions. It then runs two ripple carry chains side by side. One chain assumes the carry entering the stage is 0 and the other assumes it is 1. The real carry arriving from the stage below drives a multiplexer that picks one of the two carry vectors, and that choice gives both the stage's sum bits and its carry-out. The lowest stage is steered by the external carry-in.

Because each stage is one bit longer than the stage before it, a stage's precomputed results are ready at about the time the selected carry reaches it. The delay therefore grows with the number of stages rather than with the number of bits. The stage widths are held in a parameter array, and their sum must equal the operand width.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every pair of operands and either carry-in value, {carry-out, sum} equals the unsigned value of A + B + carry-in, with carry-out as bit 20.
- R2: The stages cover bits 1..0, 4..2, 8..5, 13..9 and 19..14. Bits 1..0 depend only on A[1:0], B[1:0] and the carry-in. A carry leaving bit 1 sets sum bit 2 when A[2] and B[2] are both 0.
- R3: In each stage, the chain that assumes a carry-in of 1 produces a 1 at every position where the chain that assumes 0 does. When every bit in a stage propagates, the stage passes its incoming carry straight through to its carry-out.
- R4: When both operand bits at the top position of a stage are 1, that stage sends a carry of 1 into the next stage, whatever its lower bits and its incoming carry are.
- R5: The carry-out is the carry leaving bit 19, which belongs to the 6-bit stage. When all operand bits propagate, the carry-out equals the carry-in and the sum equals the complement of the carry-in replicated across all bits.
- R6: Inside a stage, each sum bit equals that bit's propagate value XOR the selected carry into that bit. The selected carry into a bit is the carry out of the bit below it, and the stage's incoming carry for its lowest bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 20 | First operand |
| op_b | input | 20 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 20 | Sum bits |
| carry_out | output | 1 | Carry leaving bit 19 |

## Verification
Some checks run whenever the inputs change. The immediate assertions confirm that the two carry chains of every stage stay ordered. They confirm that a fully propagating stage gives the two chains opposite carry-outs, and that a generate at a stage's top bit forces both chains to carry. They also confirm that the whole result, and the lowest stage's result, match a behavioural sum. Other properties can only be shown by the bench's chosen operands, because each needs a specific input pattern. These are how carries cross each stage boundary (bits 1/2, 4/5, 8/9, 13/14), carries that ripple across the whole word, and carry-in steering of the lowest stage.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Carry leaving a bit position, given its propagate, generate and carry in.
  function automatic logic carry_next(input logic prop, input logic gen, input logic cin);
    return gen | (prop & cin);
  endfunction

  // Sum bit formed from propagate and the selected carry into the bit.
  function automatic logic sum_bit(input logic prop, input logic cin);
    return prop ^ cin;
  endfunction

endpackage

// File: rtl/csel_pg_setup.sv
module csel_pg_setup #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop[i] = a[i] ^ b[i];
    assign gen[i]  = a[i] & b[i];
  end

endmodule

// File: rtl/csel_carry_rail.sv
module csel_carry_rail
  import csel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         assumed_cin,
  output logic [W:0]   carries
);

  assign carries[0] = assumed_cin;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign carries[i+1] = carry_next(prop[i], gen[i], carries[i]);
  end

endmodule

// File: rtl/csel_stage.sv
module csel_stage
  import csel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_carry,
  output logic [W-1:0] sum,
  output logic         stage_cout
);

  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   rail_zero;
  logic [W:0]   rail_one;
  logic [W:0]   rail_pick;

  csel_pg_setup #(.W(W)) u_setup (
    .a    (a),
    .b    (b),
    .prop (prop),
    .gen  (gen)
  );

  csel_carry_rail #(.W(W)) u_rail0 (
    .prop        (prop),
    .gen         (gen),
    .assumed_cin (1'b0),
    .carries     (rail_zero)
  );

  csel_carry_rail #(.W(W)) u_rail1 (
    .prop        (prop),
    .gen         (gen),
    .assumed_cin (1'b1),
    .carries     (rail_one)
  );

  assign rail_pick  = sel_carry ? rail_one : rail_zero;
  assign stage_cout = rail_pick[W];

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum[i] = sum_bit(prop[i], rail_pick[i]);
  end

  always_comb begin
    AST_RAIL_ORDER: assert ((rail_zero & ~rail_one) == '0);  // R3
    if (&prop) begin
      AST_FULL_PROPAGATE: assert (rail_one[W] && !rail_zero[W]);  // R3
    end
    if (gen[W-1]) begin
      AST_TOP_GENERATE: assert (rail_zero[W] && rail_one[W]);  // R4
    end
  end

endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder #(
  parameter int WIDTH  = 20,
  parameter int NSTAGE = 5,
  parameter int STAGE_W [NSTAGE] = '{2, 3, 4, 5, 6}
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  function automatic int stage_lo(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += STAGE_W[i];
    return acc;
  endfunction

  localparam int TOTAL_W = stage_lo(NSTAGE);
  localparam int LOW_W   = STAGE_W[0];

  if (TOTAL_W != WIDTH) begin : g_bad_widths
    $error("stage widths do not add up to WIDTH");
  end

  // link[k] is the real carry entering stage k; link[NSTAGE] leaves the word.
  logic [NSTAGE:0] link;
  assign link[0] = carry_in;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int LO = stage_lo(k);
    localparam int SW = STAGE_W[k];
    csel_stage #(.W(SW)) u_stage (
      .a          (op_a[LO +: SW]),
      .b          (op_b[LO +: SW]),
      .sel_carry  (link[k]),
      .sum        (sum[LO +: SW]),
      .stage_cout (link[k+1])
    );
  end

  assign carry_out = link[NSTAGE];

  logic [WIDTH:0] behav_total;
  logic [LOW_W:0] behav_low;
  assign behav_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  assign behav_low   = {1'b0, op_a[LOW_W-1:0]} + {1'b0, op_b[LOW_W-1:0]}
                     + {{LOW_W{1'b0}}, carry_in};

  always_comb begin
    AST_TOTAL_SUM: assert ({carry_out, sum} == behav_total);  // R1
    AST_LOW_STAGE: assert (sum[LOW_W-1:0] == behav_low[LOW_W-1:0]);  // R2
  end

endmodule

// File: tb/csel_sqrt_adder_tb.sv
module csel_sqrt_adder_tb;

  typedef struct {
    logic [19:0] exp_sum;
    logic        exp_cout;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] op_a = '0;
  logic [19:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [19:0] sum;
  logic        carry_out;

  item_t sb_q[$];
  int    errors = 0;
  int    checks = 0;
  bit    driving_done = 1'b0;
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  csel_sqrt_adder u_dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  task automatic drive(input logic [19:0] a, input logic [19:0] b, input logic c, input string req);
    item_t it;
    logic [20:0] t;
    @(posedge clk);
    op_a = a;
    op_b = b;
    carry_in = c;
    t = {1'b0, a} + {1'b0, b} + {20'd0, c};
    it.exp_sum = t[19:0];
    it.exp_cout = t[20];
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, after the driver's rising-edge update.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (sum !== it.exp_sum || carry_out !== it.exp_cout) begin
        errors++;
        $display("FAIL %s: got sum=%05h cout=%0b, expected sum=%05h cout=%0b",
                 it.req, sum, carry_out, it.exp_sum, it.exp_cout);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero operands give zero result (R1)
    drive(20'h00000, 20'h00000, 1'b0, "R1 reset state");
    drive(20'h12345, 20'h0abcd, 1'b0, "R1 plain add");
    drive(20'hfffff, 20'hfffff, 1'b1, "R1 max operands");
    // R2: lowest stage steered by carry_in; carry from bit 1 into bit 2
    drive(20'h00003, 20'h00000, 1'b1, "R2 carry into bit 2");
    drive(20'h00001, 20'h00002, 1'b0, "R2 low stage no carry");
    drive(20'hffffc, 20'h00000, 1'b1, "R2 upper bits isolated");
    // R3: a fully propagating stage passes its incoming carry (bits 2..4)
    drive(20'h0001c, 20'h00002, 1'b0, "R3 stage 4..2 passes carry 0");
    drive(20'h0001e, 20'h00002, 1'b0, "R3 stage 4..2 passes carry 1");
    drive(20'h03e00, 20'h00180, 1'b0, "R3 stage 13..9 passes carry");
    // R4: generate at each stage's top bit
    drive(20'h00010, 20'h00010, 1'b0, "R4 generate bit 4");
    drive(20'h00100, 20'h00100, 1'b0, "R4 generate bit 8");
    drive(20'h02000, 20'h02000, 1'b1, "R4 generate bit 13");
    drive(20'h00002, 20'h00002, 1'b0, "R4 generate bit 1");
    // R5: full-word propagate, carry-out from bits 19..14
    drive(20'hfffff, 20'h00000, 1'b1, "R5 ripple whole word cin=1");
    drive(20'hfffff, 20'h00000, 1'b0, "R5 ripple whole word cin=0");
    drive(20'h80000, 20'h80000, 1'b0, "R5 carry-out from bit 19");
    drive(20'hfc000, 20'h04000, 1'b0, "R5 top stage overflow");
    // R6: alternating patterns exercise per-bit sum formation
    drive(20'haaaaa, 20'h55555, 1'b1, "R6 alternating ripple");
    drive(20'h5a5a5, 20'h3c3c3, 1'b0, "R6 mixed pattern");
    for (int i = 0; i < 300; i++) begin
      drive(20'($urandom), 20'($urandom), 1'($urandom), "R1 random");
    end
    driving_done = 1'b1;
    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!driving_done || sb_q.size() > 0) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
      end
    end
  end

endmodule